// File: doc/BRIEF.md
# Entropy Sampling Register Controller

This block sits between a free-running noise source and a simple 32-bit register bus. Software chooses how long a random result should be (64, 128, 192 or 256 bits). It also sets how many clock cycles separate two samples of the noise input and picks one of four speed settings, which the block drives back to the noise source. A start request makes the block capture one noise bit per sample period. It packs the captured bits into a result buffer that software reads as 32-bit words. The start bit drops by itself when the requested number of bits has been collected.

The control register takes masked writes. The upper half of each write word says which low bits the write may change, so software can set or clear single fields without reading the register first. A soft reset register returns the block to its idle state.

Top module: `trng_regctl`

## Requirements
- R1: After reset, every register reads zero (control at 0x400, sample count at 0x404, soft reset at 0x004, data words at 0x410..0x42C) and `osc_speed` is 0.
- R2: A write to 0x400 changes control bit i (i in 0..15) only when write bit 16+i is 1; bits whose mask bit is 0 keep their value.
- R3: Control bits 3:2 hold the speed setting and appear on `osc_speed` after the write that sets them.
- R4: Control bit 1 is enable and bit 0 is start. A start request while enable is 0 is ignored: start reads 0, no sampling takes place and the data words keep their contents.
- R5: While start is 1, one bit of `noise_in` is captured every N clock cycles, where N is the value at 0x404 (0 acts as 1). The first bit is captured N rising edges after the edge that accepted the start write.
- R6: Control bits 5:4 select the length L: 0 gives 64, 1 gives 128, 2 gives 192 and 3 gives 256 bits. Start reads 1 until the edge that captures bit L-1, and 0 from that edge on.
- R7: Captured bit k is stored at bit k%32 of the data word at 0x410 + 4*(k/32), so the first bit is bit 0 of the word at 0x410.
- R8: Data words at or beyond L/32 read as zero, and writes to the data words have no effect.
- R9: A new start clears the previous result and the bit position, and reads during collection return the partly filled buffer.
- R10: Writing 0 to all sixteen low control bits with a full mask clears enable and start. This stops sampling, and the buffer stays frozen.
- R11: Writing 1 to bit 0 of 0x004 clears the control, count and data registers. That bit reads 1 for exactly one cycle and then clears itself.
- R12: The sample count register at 0x404 holds and reads back a full 32-bit value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe, data returned in the same cycle |
| addr | input | 12 | Byte address of the register |
| wdata | input | 32 | Write data, upper 16 bits act as the mask for the control register |
| rdata | output | 32 | Read data, zero when rd_en is low |
| noise_in | input | 1 | Raw entropy bit from the noise source |
| osc_speed | output | 2 | Speed setting for the noise source |

## Verification
On every cycle the assertions check the following: a control write leaves its unmasked fields alone, the speed output follows a masked write, start never holds without enable, and a soft reset pulse is one cycle long and clears the control state. They also check that a new collection begins at bit position zero and that words past the selected length read as zero. The bench scenarios are needed for the exact capture cycles and the edge on which start falls, which it checks for every length and several sample periods. They also cover where each noise bit lands in the buffer, the partial contents during collection, and that data stays put after a stop or an ignored start.

// File: rtl/trng_pkg.sv
package trng_pkg;
  localparam int unsigned OFS_SRST = 32'h004;
  localparam int unsigned OFS_CTRL = 32'h400;
  localparam int unsigned OFS_CNT  = 32'h404;
  localparam int unsigned OFS_DATA = 32'h410;

  typedef struct packed {
    logic [9:0] spare;
    logic [1:0] len;
    logic [1:0] osc;
    logic       en;
    logic       start;
  } ctrl_t;
endpackage

// File: rtl/trng_ctrl_reg.sv
module trng_ctrl_reg
  import trng_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        soft_clr,
  input  logic        ctrl_wr,
  input  logic [31:0] wdata,
  input  logic        done,
  output ctrl_t       ctrl_q,
  output logic        launch
);
  ctrl_t ctrl_n;
  ctrl_t merged;

  always_comb begin
    merged = ctrl_t'((ctrl_q & ~wdata[31:16]) | (wdata[15:0] & wdata[31:16]));
    ctrl_n = ctrl_q;
    launch = 1'b0;
    if (soft_clr) begin
      ctrl_n = '0;
    end else if (ctrl_wr) begin
      ctrl_n = merged;
      if (!merged.en) begin
        ctrl_n.start = 1'b0;
      end else if (merged.start && !ctrl_q.start) begin
        launch = 1'b1;
      end else if (merged.start && done) begin
        ctrl_n.start = 1'b0;
      end
    end else if (done) begin
      ctrl_n.start = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_n;
  end
endmodule

// File: rtl/trng_sampler.sv
module trng_sampler #(
  parameter int CNT_W = 32,
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_clr,
  input  logic             launch,
  input  logic             busy,
  input  logic [CNT_W-1:0] period,
  input  logic [IDX_W:0]   target,
  output logic             capture,
  output logic [IDX_W-1:0] bit_idx,
  output logic             done
);
  logic [CNT_W-1:0] cyc_q, cyc_n;
  logic [IDX_W-1:0] idx_n;
  logic             last;
  logic [IDX_W:0]   idx_plus;

  assign last     = (period <= CNT_W'(1)) || (cyc_q >= period - CNT_W'(1));
  assign capture  = busy && last;
  assign idx_plus = {1'b0, bit_idx} + {{IDX_W{1'b0}}, 1'b1};
  assign done     = capture && (idx_plus >= target);

  always_comb begin
    cyc_n = cyc_q;
    idx_n = bit_idx;
    if (soft_clr || launch) begin
      cyc_n = '0;
      idx_n = '0;
    end else if (busy) begin
      if (last) begin
        cyc_n = '0;
        idx_n = idx_plus[IDX_W-1:0];
      end else begin
        cyc_n = cyc_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q   <= '0;
      bit_idx <= '0;
    end else begin
      cyc_q   <= cyc_n;
      bit_idx <= idx_n;
    end
  end
endmodule

// File: rtl/trng_buffer.sv
module trng_buffer #(
  parameter int MAX_WORDS = 8,
  parameter int IDX_W     = 8,
  parameter int SEL_W     = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_clr,
  input  logic             launch,
  input  logic             capture,
  input  logic [IDX_W-1:0] bit_idx,
  input  logic             bit_in,
  input  logic [SEL_W-1:0] word_sel,
  input  logic [SEL_W:0]   words_valid,
  output logic [31:0]      word_out
);
  localparam int MAX_BITS = MAX_WORDS * 32;

  logic [MAX_BITS-1:0] store_q, store_n;
  logic [31:0]         words [MAX_WORDS];

  always_comb begin
    store_n = store_q;
    if (soft_clr || launch) store_n = '0;
    else if (capture)       store_n[bit_idx] = bit_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) store_q <= '0;
    else        store_q <= store_n;
  end

  for (genvar g = 0; g < MAX_WORDS; g++) begin : g_word
    assign words[g] = store_q[g*32 +: 32];
  end

  assign word_out = ({1'b0, word_sel} < words_valid) ? words[word_sel] : 32'h0;
endmodule

// File: rtl/trng_regctl.sv
module trng_regctl
  import trng_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int CNT_W     = 32,
  parameter int MAX_WORDS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic              noise_in,
  output logic [1:0]        osc_speed
);
  localparam int MAX_BITS = MAX_WORDS * 32;
  localparam int IDX_W    = $clog2(MAX_BITS);
  localparam int SEL_W    = $clog2(MAX_WORDS);
  localparam int STEP_W   = MAX_WORDS / 4;

  logic [1:0]        sync_q;
  logic              rst_sn;
  logic              hit_ctrl, hit_cnt, hit_rst, hit_data;
  logic [ADDR_W-1:0] data_off;
  logic [SEL_W-1:0]  word_sel;
  logic              soft_clr, srst_q, srst_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  ctrl_t             ctrl_q;
  logic              launch, busy, capture, done;
  logic [IDX_W-1:0]  bit_idx;
  logic [SEL_W:0]    words_valid;
  logic [IDX_W:0]    target;
  logic [31:0]       word_out;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_sn = sync_q[1];

  assign hit_ctrl = (addr == ADDR_W'(OFS_CTRL));
  assign hit_cnt  = (addr == ADDR_W'(OFS_CNT));
  assign hit_rst  = (addr == ADDR_W'(OFS_SRST));
  assign data_off = addr - ADDR_W'(OFS_DATA);
  assign hit_data = (data_off[1:0] == 2'b00) && ((data_off >> 2) < ADDR_W'(MAX_WORDS));
  assign word_sel = data_off[SEL_W+1:2];

  assign soft_clr = wr_en && hit_rst && wdata[0];
  assign busy     = ctrl_q.start;
  assign osc_speed = ctrl_q.osc;

  assign words_valid = (SEL_W+1)'(({1'b0, ctrl_q.len} + 3'd1) * STEP_W);
  assign target      = {words_valid, 5'b00000};

  always_comb begin
    srst_n = soft_clr;
    cnt_n  = cnt_q;
    if (soft_clr)                cnt_n = '0;
    else if (wr_en && hit_cnt)   cnt_n = wdata[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      srst_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      srst_q <= srst_n;
      cnt_q  <= cnt_n;
    end
  end

  trng_ctrl_reg u_ctrl (
    .clk      (clk),
    .rst_n    (rst_sn),
    .soft_clr (soft_clr),
    .ctrl_wr  (wr_en && hit_ctrl),
    .wdata    (wdata),
    .done     (done),
    .ctrl_q   (ctrl_q),
    .launch   (launch)
  );

  trng_sampler #(.CNT_W(CNT_W), .IDX_W(IDX_W)) u_samp (
    .clk      (clk),
    .rst_n    (rst_sn),
    .soft_clr (soft_clr),
    .launch   (launch),
    .busy     (busy),
    .period   (cnt_q),
    .target   (target),
    .capture  (capture),
    .bit_idx  (bit_idx),
    .done     (done)
  );

  trng_buffer #(.MAX_WORDS(MAX_WORDS), .IDX_W(IDX_W), .SEL_W(SEL_W)) u_buf (
    .clk         (clk),
    .rst_n       (rst_sn),
    .soft_clr    (soft_clr),
    .launch      (launch),
    .capture     (capture),
    .bit_idx     (bit_idx),
    .bit_in      (noise_in),
    .word_sel    (word_sel),
    .words_valid (words_valid),
    .word_out    (word_out)
  );

  always_comb begin
    rdata = 32'h0;
    if (rd_en) begin
      if (hit_ctrl)      rdata = {16'h0, ctrl_q};
      else if (hit_cnt)  rdata = 32'(cnt_q);
      else if (hit_rst)  rdata = {31'h0, srst_q};
      else if (hit_data) rdata = word_out;
    end
  end
endmodule

// File: rtl/trng_regctl_chk.sv
module trng_regctl_chk #(
  parameter int ADDR_W = 12,
  parameter int IDX_W  = 8
) (
  input logic              clk,
  input logic              rst_sn,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wdata,
  input logic [31:0]       rdata,
  input logic [1:0]        osc_speed,
  input logic [15:0]       ctrl_q,
  input logic              srst_q,
  input logic              busy,
  input logic [IDX_W-1:0]  bit_idx
);
  logic ctrl_w;
  assign ctrl_w = wr_en && (addr == ADDR_W'(32'h400));

  p_masked_hold_r2: assert property (@(posedge clk) disable iff (!rst_sn)
    (ctrl_w && wdata[31:18] == 14'h0) |=> (ctrl_q[15:2] == $past(ctrl_q[15:2])));

  p_osc_follow_r3: assert property (@(posedge clk) disable iff (!rst_sn)
    (ctrl_w && wdata[19:18] == 2'b11) |=> (osc_speed == $past(wdata[3:2])));

  p_start_needs_en_r4: assert property (@(posedge clk) disable iff (!rst_sn)
    ctrl_q[0] |-> ctrl_q[1]);

  p_fresh_start_r9: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(busy) |-> (bit_idx == '0));

  p_tail_zero_r8: assert property (@(posedge clk) disable iff (!rst_sn)
    (rd_en && addr == ADDR_W'(32'h42C) && ctrl_q[5:4] != 2'b11) |-> (rdata == 32'h0));

  p_srst_pulse_r11: assert property (@(posedge clk) disable iff (!rst_sn)
    srst_q |=> !srst_q);

  p_srst_clears_r11: assert property (@(posedge clk) disable iff (!rst_sn)
    srst_q |-> (ctrl_q == 16'h0));
endmodule

bind trng_regctl trng_regctl_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst_sn    (rst_sn),
  .wr_en     (wr_en),
  .rd_en     (rd_en),
  .addr      (addr),
  .wdata     (wdata),
  .rdata     (rdata),
  .osc_speed (osc_speed),
  .ctrl_q    (ctrl_q),
  .srst_q    (srst_q),
  .busy      (busy),
  .bit_idx   (bit_idx)
);

// File: tb/trng_regctl_bench.sv
module trng_regctl_bench;
  logic        clk;
  logic        rst_n;
  logic        wr_en, rd_en;
  logic [11:0] addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        noise_in;
  logic [1:0]  osc_speed;

  int unsigned cyc;
  int          checks;
  int          errors;
  bit          finished;

  trng_regctl u_trng_regctl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .noise_in(noise_in), .osc_speed(osc_speed)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic pat(int unsigned x);
    logic [31:0] h;
    h = x * 32'h9E3779B1;
    return h[16] ^ h[27];
  endfunction

  always @(negedge clk) noise_in <= pat(cyc);

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual cyc %0d expected below 150000", cyc);
      report();
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic bwrite(logic [11:0] a, logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic bpeek(logic [11:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    #1;
    d = rdata;
    rd_en = 1'b0;
  endtask

  task automatic bread(logic [11:0] a, output logic [31:0] d);
    bpeek(a, d);
    @(negedge clk);
  endtask

  function automatic logic [31:0] exp_word(int w, int s, int per, int nbits, int lim);
    logic [31:0] v;
    v = '0;
    for (int b = 0; b < 32; b++) begin
      int k;
      k = w * 32 + b;
      if (k < nbits && k < lim) v[b] = pat(s + (k + 1) * per - 1);
    end
    return v;
  endfunction

  // R5 R6 R7 R8: one full collection with length code len and period n
  task automatic run(int len, int n);
    logic [31:0] d;
    int s, per, nbits;
    per   = (n == 0) ? 1 : n;
    nbits = (len + 1) * 64;
    bwrite(12'h404, n);
    bwrite(12'h400, 32'h003F_0003 | (len << 4));
    s = cyc;
    while (cyc != s + nbits * per - 1) @(negedge clk);
    bpeek(12'h400, d);
    check("R6 start held before last bit", {31'h0, d[0]}, 32'h1);
    @(negedge clk);
    bpeek(12'h400, d);
    check("R6 start cleared on last bit", {31'h0, d[0]}, 32'h0);
    for (int w = 0; w < 8; w++) begin
      bread(12'h410 + 12'(4 * w), d);
      check("R7 R5 R8 data word", d, exp_word(w, s, per, nbits, nbits));
    end
  endtask

  initial begin
    logic [31:0] d, w0;
    int s;
    checks = 0; errors = 0; finished = 1'b0; cyc = 0;
    wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    bread(12'h400, d); check("R1 ctrl", d, 0);
    bread(12'h404, d); check("R1 count", d, 0);
    bread(12'h004, d); check("R1 srst", d, 0);
    for (int w = 0; w < 8; w++) begin
      bread(12'h410 + 12'(4 * w), d); check("R1 data", d, 0);
    end
    check("R1 osc_speed", {30'h0, osc_speed}, 0);

    // R2 masked writes, R3 speed output
    bwrite(12'h400, 32'h00F0_FFFF);
    bread(12'h400, d); check("R2 masked set", d, 32'h00F0);
    bwrite(12'h400, 32'h0040_0000);
    bread(12'h400, d); check("R2 masked clear", d, 32'h00B0);
    bwrite(12'h400, 32'h000C_000C);
    bread(12'h400, d); check("R2 unmasked kept", d, 32'h00BC);
    check("R3 speed output", {30'h0, osc_speed}, 32'h3);
    bwrite(12'h400, 32'h0008_0000);
    check("R3 speed partial", {30'h0, osc_speed}, 32'h1);
    bwrite(12'h400, 32'hFFFF_0000);

    // R12 count register
    bwrite(12'h404, 32'hDEAD_BEEF);
    bread(12'h404, d); check("R12 count readback", d, 32'hDEAD_BEEF);

    // R5 R6 R7 R8 sweep over lengths and periods
    for (int len = 0; len < 4; len++)
      for (int n = 1; n <= 3; n++) run(len, n);
    run(0, 0);

    // R8 data writes ignored (length 64 is selected now)
    bread(12'h410, w0);
    bwrite(12'h410, 32'h1234_5678);
    bwrite(12'h42C, 32'hFFFF_FFFF);
    bread(12'h410, d); check("R8 data write ignored", d, w0);
    bread(12'h42C, d); check("R8 beyond length zero", d, 0);

    // R9 new start clears old result, partial reads
    bwrite(12'h404, 2);
    bwrite(12'h400, 32'h003F_0033);
    s = cyc;
    while (cyc != s + 41) @(negedge clk);
    bpeek(12'h410, d); check("R9 partial word0", d, exp_word(0, s, 2, 256, 20));
    bpeek(12'h414, d); check("R9 old data cleared", d, 0);

    // R10 stop
    bwrite(12'h400, 32'hFFFF_0000);
    bread(12'h400, d); check("R10 stop clears ctrl", d, 0);
    bread(12'h410, w0);
    repeat (10) @(negedge clk);
    bread(12'h410, d); check("R10 buffer frozen", d, w0);

    // R4 start without enable ignored
    bwrite(12'h400, 32'h0001_0001);
    bread(12'h400, d); check("R4 start stays 0", d, 0);
    repeat (10) @(negedge clk);
    bread(12'h410, d); check("R4 data untouched", d, w0);

    // R11 soft reset
    bwrite(12'h404, 5);
    bwrite(12'h400, 32'h003F_003E);
    bpeek(12'h004, d);
    bwrite(12'h004, 32'h1);
    bpeek(12'h004, d); check("R11 srst reads 1", d, 1);
    @(negedge clk);
    bread(12'h004, d); check("R11 srst self-clears", d, 0);
    bread(12'h400, d); check("R11 ctrl cleared", d, 0);
    bread(12'h404, d); check("R11 count cleared", d, 0);
    bread(12'h410, d); check("R11 data cleared", d, 0);
    check("R11 speed cleared", {30'h0, osc_speed}, 0);

    report();
  end
endmodule